// File: doc/BRIEF.md
# Chunked Image Transfer Sequencer

This block is a bus master that moves a firmware image from a local word-addressed buffer into a mailbox peripheral. The peripheral exposes four 32-bit registers: control, status, write data and read data. A single start pulse launches a transfer. The sequencer resets the peripheral and then repeats the same round trip. It writes one chunk wrapped in a request, triggers the peripheral and polls it until it is ready. It then drains a four-word response that names the image offset the peripheral wants next.

The peripheral, not the sequencer, chooses each next offset, so a piece of the image may be sent more than once. The total number of bytes sent is capped at twice the image length. The transfer ends when any of these happens:
- the peripheral reports the end marker;
- the byte budget would be exceeded;
- the peripheral flags an error;
- polling runs out;
- a response is malformed.

The sequencer then raises `done` together with an error code. Both stay unchanged until the next start.

Top module: `stx_sequencer`

## Requirements
- R1: An image length that is not a multiple of 4 bytes is refused at start. The result is `done` with error code 1 (misaligned), and no register access is made.
- R2: The first access of every accepted transfer writes value 1 (abort, bit 0) to the control register at byte offset 0x0. No status read comes between this write and the first request word.
- R3: Each chunk is the smaller of PAGE_BYTES and (image length − current offset). The request written to the write-data register (0xC is read data, 0x8 is write data) is, in order:
  - the mailbox tag;
  - the total request size in 32-bit words, (16 + chunk)/4;
  - the load command word 3;
  - a zero word;
  - the chunk's buffer words, starting at word address offset/4.
  A write of bit 31 (go) to the control register follows the request.
- R4: Before each chunk, if bytes already sent plus the new chunk size exceed twice the image length, the transfer ends with error code 2 (overrun). Equality is allowed.
- R5: After go, the sequencer waits POLL_CYCLES cycles before each read of the status register (0x4), and makes at most MAX_POLLS reads. Status bit 31 is ready. If ready never appears, the result is error code 4 (timeout).
- R6: If status bit 2 is set when polling stops, the result is error code 3 (I/O error).
- R7: The response is four reads of the read-data register (0xC), each followed by a write of 0 to 0xC. Its first two words must equal the mailbox tag and 4, otherwise the result is error code 5 (bad header).
- R8: A response offset of 0xFFFFFFFF ends the transfer with code 0 (none). Any other offset above the image length gives code 6 (bad offset). An offset at or below the length becomes the next chunk's start, including offsets already sent. Header is checked before offset.
- R9: A response whose fourth word has bit 2 set ends the transfer with error code 7 (protocol error). This check comes after the header and offset checks.
- R10: `done` and `err_code` stay unchanged until the next start. A register request holds its address, direction and data until acknowledged. After reset `done` and `reg_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a transfer (taken when idle or finished) |
| img_len | input | LEN_W | Image length in bytes |
| buf_addr | output | LEN_W-2 | Word address into the image buffer |
| buf_rdata | input | 32 | Buffer word at buf_addr (same cycle) |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 4 | Register byte offset |
| reg_wdata | output | 32 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | 32 | Read data, valid with reg_ack |
| done | output | 1 | Transfer finished |
| err_code | output | 3 | Result code, valid while done |

## Verification
The hardest state to reach is the byte budget boundary. It needs a peripheral that keeps sending the sequencer back to earlier offsets until the running byte count lands exactly on twice the image length, or one chunk past it. The bench's peripheral model replays a scripted list of next offsets per scenario, so one script ends exactly on the budget and another overshoots it. Error paths such as the never-ready peripheral and an error flag raised without ready are reached by setting the model's ready delay and status flags per task.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_MISALIGN = 3'd1,
        ERR_OVERRUN  = 3'd2,
        ERR_IO       = 3'd3,
        ERR_TIMEOUT  = 3'd4,
        ERR_BAD_HDR  = 3'd5,
        ERR_BAD_OFS  = 3'd6,
        ERR_PROTO    = 3'd7
    } stx_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ABORT, S_CHECK, S_HDR_LO, S_HDR_HI, S_CMD_LO, S_CMD_HI,
        S_DATA, S_GO, S_WAIT, S_POLL, S_RSP_RD, S_RSP_ACK, S_EVAL, S_FIN
    } stx_state_e;

    typedef struct packed {
        logic        req;
        logic        we;
        logic [3:0]  addr;
        logic [31:0] wdata;
    } stx_bus_t;

    localparam logic [3:0]  REG_CTRL = 4'h0;
    localparam logic [3:0]  REG_STAT = 4'h4;
    localparam logic [3:0]  REG_WDAT = 4'h8;
    localparam logic [3:0]  REG_RDAT = 4'hC;

    localparam int          CTRL_ABORT_BIT = 0;
    localparam int          CTRL_GO_BIT    = 31;
    localparam int          STAT_READY_BIT = 31;
    localparam int          STAT_ERR_BIT   = 2;
    localparam int          RSP_ERR_BIT    = 2;

    localparam logic [31:0] CMD_LOAD  = 32'd3;
    localparam logic [31:0] END_OFS   = 32'hFFFF_FFFF;
    localparam int          HDR_BYTES = 8;

    // Number of 32-bit words in a mailbox object of the given byte size.
    function automatic logic [31:0] to_dwords(input logic [31:0] nbytes);
        return nbytes >> 2;
    endfunction

endpackage

// File: rtl/stx_chunk_calc.sv
module stx_chunk_calc #(
    parameter int LEN_W      = 20,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] ofs,
    input  logic [LEN_W:0]   sent,
    output logic [LEN_W-1:0] chunk,
    output logic             over
);
    localparam logic [LEN_W-1:0] PAGE_L = LEN_W'(PAGE_BYTES);

    logic [LEN_W-1:0] remain;
    logic [LEN_W+1:0] total;

    always_comb begin
        remain = len - ofs;
        chunk  = (remain > PAGE_L) ? PAGE_L : remain;
        total  = (LEN_W+2)'(sent) + (LEN_W+2)'(chunk);
        over   = total > (LEN_W+2)'({len, 1'b0});
    end
endmodule

// File: rtl/stx_poll_timer.sv
module stx_poll_timer #(
    parameter int POLL_CYCLES = 125000,
    parameter int MAX_POLLS   = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr_polls,
    input  logic poll_ack,
    output logic tick,
    output logic last_poll
);
    localparam int CW = $clog2(POLL_CYCLES + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_q;
    logic [PW-1:0] polls_q;

    assign tick      = run && (cnt_q == CW'(POLL_CYCLES - 1));
    assign last_poll = (polls_q == PW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_polls) polls_q <= '0;
        else if (poll_ack)    polls_q <= polls_q + 1'b1;
    end

    // R5: the status read count never passes its bound
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (rst)
        polls_q <= PW'(MAX_POLLS));

    // R5: the interval counter restarts whenever waiting stops
    p_idle_clear_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/stx_sequencer.sv
module stx_sequencer
    import stx_pkg::*;
#(
    parameter int          LEN_W       = 20,
    parameter int          PAGE_BYTES  = 4096,
    parameter int          POLL_CYCLES = 125000,
    parameter int          MAX_POLLS   = 10000,
    parameter logic [31:0] MBOX_TAG    = 32'h000B_1D0C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] img_len,
    output logic [LEN_W-3:0] buf_addr,
    input  logic [31:0]      buf_rdata,
    output logic             reg_req,
    output logic             reg_we,
    output logic [3:0]       reg_addr,
    output logic [31:0]      reg_wdata,
    input  logic             reg_ack,
    input  logic [31:0]      reg_rdata,
    output logic             done,
    output logic [2:0]       err_code
);
    localparam int          AW       = LEN_W - 2;
    localparam logic [31:0] RSP_SIZE = to_dwords(32'(2 * HDR_BYTES));

    stx_state_e       state_q;
    stx_err_e         err_q;
    stx_bus_t         bus;
    logic [LEN_W-1:0] len_q;
    logic [31:0]      ofs_q;
    logic [LEN_W:0]   sent_q;
    logic [LEN_W-1:0] chunk_q;
    logic [AW-1:0]    widx_q;
    logic [1:0]       ridx_q;
    logic [31:0]      rsp_hdr_lo_q, rsp_hdr_hi_q, rsp_ofs_q;
    logic             rsp_err_q;

    logic [LEN_W-1:0] next_chunk;
    logic             budget_over;
    logic             poll_tick, poll_last;
    logic             acked;

    stx_chunk_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_calc (
        .len   (len_q),
        .ofs   (ofs_q[LEN_W-1:0]),
        .sent  (sent_q),
        .chunk (next_chunk),
        .over  (budget_over)
    );

    stx_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q == S_WAIT),
        .clr_polls (state_q == S_GO),
        .poll_ack  (state_q == S_POLL && reg_ack),
        .tick      (poll_tick),
        .last_poll (poll_last)
    );

    // Register port request, decoded from the current step
    always_comb begin
        bus = '0;
        unique case (state_q)
            S_ABORT:   bus = '{1'b1, 1'b1, REG_CTRL, 32'(1) << CTRL_ABORT_BIT};
            S_HDR_LO:  bus = '{1'b1, 1'b1, REG_WDAT, MBOX_TAG};
            S_HDR_HI:  bus = '{1'b1, 1'b1, REG_WDAT,
                               to_dwords(32'(chunk_q) + 32'(2 * HDR_BYTES))};
            S_CMD_LO:  bus = '{1'b1, 1'b1, REG_WDAT, CMD_LOAD};
            S_CMD_HI:  bus = '{1'b1, 1'b1, REG_WDAT, 32'd0};
            S_DATA:    bus = '{1'b1, 1'b1, REG_WDAT, buf_rdata};
            S_GO:      bus = '{1'b1, 1'b1, REG_CTRL, 32'(1) << CTRL_GO_BIT};
            S_POLL:    bus = '{1'b1, 1'b0, REG_STAT, 32'd0};
            S_RSP_RD:  bus = '{1'b1, 1'b0, REG_RDAT, 32'd0};
            S_RSP_ACK: bus = '{1'b1, 1'b1, REG_RDAT, 32'd0};
            default:   bus = '0;
        endcase
    end

    assign reg_req   = bus.req;
    assign reg_we    = bus.we;
    assign reg_addr  = bus.addr;
    assign reg_wdata = bus.wdata;
    assign acked     = bus.req && reg_ack;
    assign buf_addr  = ofs_q[LEN_W-1:2] + widx_q;
    assign done      = (state_q == S_FIN);
    assign err_code  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            err_q        <= ERR_NONE;
            len_q        <= '0;
            ofs_q        <= '0;
            sent_q       <= '0;
            chunk_q      <= '0;
            widx_q       <= '0;
            ridx_q       <= '0;
            rsp_hdr_lo_q <= '0;
            rsp_hdr_hi_q <= '0;
            rsp_ofs_q    <= '0;
            rsp_err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE, S_FIN: if (start) begin
                    len_q  <= img_len;
                    ofs_q  <= '0;
                    sent_q <= '0;
                    if (img_len[1:0] != 2'b00) begin
                        err_q   <= ERR_MISALIGN;
                        state_q <= S_FIN;
                    end else begin
                        err_q   <= ERR_NONE;
                        state_q <= S_ABORT;
                    end
                end
                S_ABORT:  if (acked) state_q <= S_CHECK;
                S_CHECK: begin
                    if (budget_over) begin
                        err_q   <= ERR_OVERRUN;
                        state_q <= S_FIN;
                    end else begin
                        chunk_q <= next_chunk;
                        sent_q  <= sent_q + (LEN_W+1)'(next_chunk);
                        widx_q  <= '0;
                        state_q <= S_HDR_LO;
                    end
                end
                S_HDR_LO: if (acked) state_q <= S_HDR_HI;
                S_HDR_HI: if (acked) state_q <= S_CMD_LO;
                S_CMD_LO: if (acked) state_q <= S_CMD_HI;
                S_CMD_HI: if (acked) state_q <= (chunk_q == '0) ? S_GO : S_DATA;
                S_DATA: if (acked) begin
                    if (widx_q == AW'(chunk_q >> 2) - 1'b1) state_q <= S_GO;
                    else                                   widx_q  <= widx_q + 1'b1;
                end
                S_GO:   if (acked) state_q <= S_WAIT;
                S_WAIT: if (poll_tick) state_q <= S_POLL;
                S_POLL: if (acked) begin
                    if (reg_rdata[STAT_READY_BIT] || poll_last) begin
                        if (reg_rdata[STAT_ERR_BIT]) begin
                            err_q   <= ERR_IO;
                            state_q <= S_FIN;
                        end else if (!reg_rdata[STAT_READY_BIT]) begin
                            err_q   <= ERR_TIMEOUT;
                            state_q <= S_FIN;
                        end else begin
                            ridx_q  <= '0;
                            state_q <= S_RSP_RD;
                        end
                    end else begin
                        state_q <= S_WAIT;
                    end
                end
                S_RSP_RD: if (acked) begin
                    unique case (ridx_q)
                        2'd0:    rsp_hdr_lo_q <= reg_rdata;
                        2'd1:    rsp_hdr_hi_q <= reg_rdata;
                        2'd2:    rsp_ofs_q    <= reg_rdata;
                        default: rsp_err_q    <= reg_rdata[RSP_ERR_BIT];
                    endcase
                    state_q <= S_RSP_ACK;
                end
                S_RSP_ACK: if (acked) begin
                    if (ridx_q == 2'd3) state_q <= S_EVAL;
                    else begin
                        ridx_q  <= ridx_q + 1'b1;
                        state_q <= S_RSP_RD;
                    end
                end
                S_EVAL: begin
                    if (rsp_hdr_lo_q != MBOX_TAG || rsp_hdr_hi_q != RSP_SIZE) begin
                        err_q   <= ERR_BAD_HDR;
                        state_q <= S_FIN;
                    end else if (rsp_ofs_q != END_OFS && rsp_ofs_q > 32'(len_q)) begin
                        err_q   <= ERR_BAD_OFS;
                        state_q <= S_FIN;
                    end else if (rsp_err_q) begin
                        err_q   <= ERR_PROTO;
                        state_q <= S_FIN;
                    end else begin
                        ofs_q   <= rsp_ofs_q;
                        state_q <= (rsp_ofs_q == END_OFS) ? S_FIN : S_CHECK;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R10: a pending request stays put until acknowledged
    p_hold_bus_r10: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_addr)
                                && $stable(reg_wdata));

    // R10: result is frozen while done and no new start arrives
    p_err_hold_r10: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(err_code));

    // R4: bytes handed over never pass twice the image length
    p_budget_r4: assert property (@(posedge clk) disable iff (rst)
        sent_q <= {len_q, 1'b0});

    // R3: a chunk is never larger than one page
    p_chunk_page_r3: assert property (@(posedge clk) disable iff (rst)
        chunk_q <= LEN_W'(PAGE_BYTES));

    // R8: a clean finish only follows the end marker
    p_clean_end_r8: assert property (@(posedge clk) disable iff (rst)
        done && err_code == ERR_NONE |-> ofs_q == END_OFS);

    // R1: a misaligned length never reaches the register port
    p_misalign_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        done && err_code == ERR_MISALIGN |-> !reg_req);
endmodule

// File: tb/sim_stx_sequencer.sv
module sim_stx_sequencer;
    localparam int          LEN_W = 12;
    localparam int          PAGE  = 16;
    localparam int          PCYC  = 3;
    localparam int          MAXP  = 5;
    localparam logic [31:0] TAG   = 32'h00C0_FFEE;
    localparam logic [31:0] ENDM  = 32'hFFFF_FFFF;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [LEN_W-1:0] img_len = '0;
    logic [LEN_W-3:0] buf_addr;
    logic [31:0]      buf_rdata;
    logic             reg_req, reg_we, reg_ack;
    logic [3:0]       reg_addr;
    logic [31:0]      reg_wdata, reg_rdata;
    logic             done;
    logic [2:0]       err_code;

    always #4 clk = ~clk;

    assign buf_rdata = 32'hA500_0000 | 32'(buf_addr);

    stx_sequencer #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE), .POLL_CYCLES(PCYC),
                    .MAX_POLLS(MAXP), .MBOX_TAG(TAG)) u0 (
        .clk(clk), .rst(rst), .start(start), .img_len(img_len),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .done(done), .err_code(err_code)
    );

    // Scenario configuration, set by tasks
    logic [31:0] plan [0:7];
    int          rdy_delay;
    logic        stat_err;
    logic [31:0] rsp_tag;
    logic [31:0] rsp_stat;
    logic        clr;

    // Peripheral model statistics
    int          abort_cnt, go_cnt, poll_reads, rd_acks, hdr_bad, data_bad;
    int          status_before_req;
    int          wcnt, elapsed, rptr;
    logic [31:0] ws [0:3];
    logic [15:0] first_idx;
    int          txn_words [0:7];
    int          txn_first [0:7];

    initial begin
        reg_ack   = 1'b0;
        reg_rdata = '0;
    end

    always @(posedge clk) begin
        elapsed <= elapsed + 1;
        reg_ack <= 1'b0;
        if (clr) begin
            abort_cnt <= 0; go_cnt <= 0; poll_reads <= 0; rd_acks <= 0;
            hdr_bad <= 0; data_bad <= 0; status_before_req <= 0;
            wcnt <= 0; rptr <= 0; elapsed <= 0;
        end else if (reg_req && !reg_ack) begin
            reg_ack <= 1'b1;
            if (reg_we) begin
                case (reg_addr)
                    4'h0: begin
                        if (reg_wdata[0]) begin
                            abort_cnt <= abort_cnt + 1;
                            wcnt <= 0;
                        end
                        if (reg_wdata[31]) begin
                            if (ws[0] != TAG || ws[1] != 32'(wcnt) ||
                                ws[2] != 32'd3 || ws[3] != 32'd0)
                                hdr_bad <= hdr_bad + 1;
                            if (go_cnt < 8) begin
                                txn_words[go_cnt] <= wcnt - 4;
                                txn_first[go_cnt] <= int'(first_idx);
                            end
                            go_cnt  <= go_cnt + 1;
                            wcnt    <= 0;
                            rptr    <= 0;
                            elapsed <= 0;
                        end
                    end
                    4'h8: begin
                        if (wcnt < 4) ws[wcnt] <= reg_wdata;
                        else if (wcnt == 4) first_idx <= reg_wdata[15:0];
                        else if (reg_wdata != (32'hA500_0000 |
                                 32'(first_idx + 16'(wcnt - 4))))
                            data_bad <= data_bad + 1;
                        wcnt <= wcnt + 1;
                    end
                    4'hC: begin
                        rptr    <= rptr + 1;
                        rd_acks <= rd_acks + 1;
                    end
                    default: ;
                endcase
            end else begin
                case (reg_addr)
                    4'h4: begin
                        poll_reads <= poll_reads + 1;
                        if (go_cnt == 0) status_before_req <= status_before_req + 1;
                        reg_rdata <= ((elapsed >= rdy_delay) ? 32'h8000_0000 : 32'h0)
                                   | (stat_err ? 32'h4 : 32'h0);
                    end
                    4'hC: begin
                        case (rptr)
                            0:       reg_rdata <= rsp_tag;
                            1:       reg_rdata <= 32'd4;
                            2:       reg_rdata <= plan[(go_cnt - 1) & 7];
                            default: reg_rdata <= rsp_stat;
                        endcase
                    end
                    default: reg_rdata <= '0;
                endcase
            end
        end
    end

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input int dly, input logic serr, input logic [31:0] tag,
                         input logic [31:0] st);
        rdy_delay = dly;
        stat_err  = serr;
        rsp_tag   = tag;
        rsp_stat  = st;
        for (int i = 0; i < 8; i++) plan[i] = ENDM;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic run(input int len);
        @(negedge clk);
        img_len = LEN_W'(len);
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
    endtask

    // R2 R3 R7 R8 R10: sequential three-chunk transfer
    task automatic t_sequential();
        logic [2:0] held;
        setup(2, 1'b0, TAG, 32'h1);
        plan[0] = 32'd16; plan[1] = 32'd32; plan[2] = ENDM;
        run(40);
        chk(done && err_code == 3'd0, "R8 clean end", int'(err_code), 0);
        chk(abort_cnt == 1 && status_before_req == 0, "R2 single abort first", abort_cnt, 1);
        chk(go_cnt == 3, "R3 transaction count", go_cnt, 3);
        chk(txn_words[0] == 4 && txn_words[1] == 4 && txn_words[2] == 2,
            "R3 chunk sizes", txn_words[2], 2);
        chk(txn_first[1] == 4 && txn_first[2] == 8, "R3 chunk start", txn_first[2], 8);
        chk(hdr_bad == 0 && data_bad == 0, "R3 request words", hdr_bad + data_bad, 0);
        chk(rd_acks == 12, "R7 response read acks", rd_acks, 12);
        held = err_code;
        repeat (10) @(negedge clk);
        chk(done && err_code == held, "R10 result held", int'(err_code), int'(held));
    endtask

    // R4 R8: resends that end exactly on the budget
    task automatic t_resend_exact();
        setup(1, 1'b0, TAG, 32'h1);
        plan[0] = 32'd16; plan[1] = 32'd0; plan[2] = 32'd16; plan[3] = ENDM;
        run(24);
        chk(done && err_code == 3'd0, "R4 budget equality allowed", int'(err_code), 0);
        chk(go_cnt == 4, "R8 resend count", go_cnt, 4);
        chk(txn_first[2] == 0 && txn_words[2] == 4 && txn_words[3] == 2,
            "R8 resend follows offset", txn_first[2], 0);
    endtask

    // R4: resends that would exceed the budget
    task automatic t_overrun();
        setup(1, 1'b0, TAG, 32'h1);
        plan[0] = 32'd16; plan[1] = 32'd0; plan[2] = 32'd0; plan[3] = 32'd0;
        run(24);
        chk(done && err_code == 3'd2, "R4 overrun code", int'(err_code), 2);
        chk(go_cnt == 3, "R4 no chunk past budget", go_cnt, 3);
    endtask

    // R1: misaligned length refused
    task automatic t_misaligned();
        setup(1, 1'b0, TAG, 32'h1);
        run(22);
        chk(done && err_code == 3'd1, "R1 misaligned code", int'(err_code), 1);
        chk(abort_cnt == 0 && go_cnt == 0, "R1 no access", abort_cnt + go_cnt, 0);
    endtask

    // R5: peripheral never ready
    task automatic t_timeout();
        setup(100000, 1'b0, TAG, 32'h1);
        run(8);
        chk(done && err_code == 3'd4, "R5 timeout code", int'(err_code), 4);
        chk(poll_reads == MAXP, "R5 poll count", poll_reads, MAXP);
    endtask

    // R6: status error bit
    task automatic t_io_error();
        setup(0, 1'b1, TAG, 32'h1);
        run(8);
        chk(done && err_code == 3'd3, "R6 io error code", int'(err_code), 3);
        chk(poll_reads == 1 && rd_acks == 0, "R6 stops at first ready", poll_reads, 1);
    endtask

    // R6: error flag without ready keeps polling, then I/O error
    task automatic t_io_not_ready();
        setup(100000, 1'b1, TAG, 32'h1);
        run(8);
        chk(done && err_code == 3'd3 && poll_reads == MAXP, "R6 error after poll budget",
            int'(err_code), 3);
    endtask

    // R7: bad response header
    task automatic t_bad_header();
        setup(1, 1'b0, TAG ^ 32'h1, 32'h1);
        run(8);
        chk(done && err_code == 3'd5, "R7 bad header code", int'(err_code), 5);
    endtask

    // R8: offset past image end, and offset equal to the end
    task automatic t_offsets();
        setup(1, 1'b0, TAG, 32'h1);
        plan[0] = 32'd20;
        run(16);
        chk(done && err_code == 3'd6, "R8 bad offset code", int'(err_code), 6);
        setup(1, 1'b0, TAG, 32'h1);
        plan[0] = 32'd16; plan[1] = ENDM;
        run(16);
        chk(done && err_code == 3'd0 && go_cnt == 2 && txn_words[1] == 0,
            "R8 offset at length gives empty chunk", txn_words[1], 0);
        chk(hdr_bad == 0, "R3 empty chunk size word", hdr_bad, 0);
    endtask

    // R9: response error flag
    task automatic t_proto();
        setup(1, 1'b0, TAG, 32'h4);
        plan[0] = 32'd8;
        run(16);
        chk(done && err_code == 3'd7, "R9 protocol code", int'(err_code), 7);
    endtask

    initial begin
        clr = 1'b0;
        rdy_delay = 0; stat_err = 1'b0; rsp_tag = TAG; rsp_stat = 32'h1;
        for (int i = 0; i < 8; i++) plan[i] = ENDM;
        clr = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        clr = 1'b0;
        @(negedge clk);
        chk(!done && !reg_req && err_code == 3'd0, "R10 reset state", int'(done), 0);
        t_sequential();
        t_resend_exact();
        t_overrun();
        t_misaligned();
        t_timeout();
        t_io_error();
        t_io_not_ready();
        t_bad_header();
        t_offsets();
        t_proto();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end
endmodule